// File: doc/BRIEF.md
# Transmit Descriptor Ring Pointer Controller

This block keeps the pointer state of one transmit descriptor ring that lives in host memory, for a single DMA channel. Software programs a ring length and a start offset, then posts descriptors by writing a tail index together with a wrap bit (a "kick"). The packet engine takes descriptors one at a time through a request/acknowledge handshake. Each acknowledged request moves the hardware head forward by one entry. The head wraps to entry 0 at the end of the ring and toggles its own wrap bit at that point. Full and empty are found by comparing the head and tail indices and their wrap bits.

The block also runs the channel life cycle through a four-state machine. IDLE is disabled and quiescent. RUN is enabled. DRAIN is disabled while the packet engine still reports work in flight. RESET runs for a fixed number of cycles with all channel state cleared. The transitions are as follows:
- IDLE to RUN on an enable write.
- RUN to DRAIN on a disable write, on a fatal event, or on an overflowing kick.
- DRAIN to IDLE once the engine is no longer busy.
- DRAIN to RUN on an enable write.
- Any state to RESET on a reset write.
- RESET to IDLE after the reset count runs out.

An enable write is refused while a fatal condition is still pending, whether it came from the external input or from a detected ring overflow.

Top module: `tx_ring_ctrl`

Register map, with `N` = `IDX_W`. Reads are combinational on `rd_addr`.
- Address 0, control: bit 0 enable, bit 1 reset (write 1 to start; reads 1 while reset runs), bit 2 quiescent (read only).
- Address 1: ring length.
- Address 2: start offset.
- Address 3, kick: tail in bits [N-1:0], tail wrap in bit N.
- Address 4, head (read only): head in bits [N-1:0], head wrap in bit N.
- Address 5, status: bit 0 full, bit 1 empty, bit 2 overflow pending (write 1 to clear), bit 3 external fatal pending (write 1 to clear).

## Requirements
- R1: After `rst_n` is released, the block is disabled and quiescent (control reads 0x4). The head index and head wrap are 0. Status reads 0x2 (empty).
- R2: The bits of the ring length below `GRAN` always read as zero, whatever value was written. The effective length is the value that reads back.
- R3: `cons_ack` equals `cons_req` while the channel is enabled and the ring is not empty, and is 0 otherwise. The head advances by exactly one on each acknowledge and never without one.
- R4: When the head advances from entry length-1, it returns to 0 and its wrap bit toggles.
- R5: Status bit 0 (full) is set exactly when head equals tail and the wrap bits differ. Status bit 1 (empty) is set exactly when head equals tail and the wrap bits match.
- R6: A kick written while the channel is enabled raises overflow (status bit 2) and clears enable in either of two cases. The first case is a tail at or beyond the ring length. The second case is a tail whose position contradicts the wrap bits: with equal wrap bits the tail must not be behind the head, and with different wrap bits the tail must not be ahead of the head.
- R7: A kick written while the channel is disabled never raises overflow, even when its tail is out of range.
- R8: Writing 1 to control bit 1 starts a reset. Control bit 1 reads 1 for `RST_CYC` cycles and then clears by itself. After that, length, start offset, tail, head, both wrap bits, both pending flags and enable are all back at their power-on values.
- R9: A pulse on `fatal_in` clears enable and sets status bit 3. While status bit 2 or status bit 3 is set, an enable write leaves the channel disabled. Once both bits are cleared by writing 1 to them, an enable write succeeds.
- R10: Writes to the ring length and the start offset are ignored while the channel is enabled.
- R11: Quiescent is high only when the channel is disabled and `eng_busy` is low. It drops in the cycle after an enable write is accepted. After a disable with `eng_busy` high, it stays low until one cycle after `eng_busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DW | Register read data (combinational) |
| cons_req | input | 1 | Packet engine asks for the next descriptor |
| cons_ack | output | 1 | Request granted; head advances at this edge |
| eng_busy | input | 1 | Packet engine still working on a taken descriptor |
| fatal_in | input | 1 | Fatal error event from elsewhere in the channel |
| enable | output | 1 | Channel enabled (RUN state) |
| quiescent | output | 1 | Channel idle and back at initial state |
| full | output | 1 | Ring full |
| empty | output | 1 | Ring empty |
| head_idx | output | IDX_W | Current head entry |
| head_wrap | output | 1 | Current head wrap bit |

## Verification
The bench builds the block with `IDX_W` = 8, `GRAN` = 2 and `RST_CYC` = 3. A ring length of 12 entries is then legal, and the head passes its wrap point many times within a few hundred random kicks and consumes. The narrow index also makes an out-of-range tail and a tail that contradicts the wrap bits easy to produce. The short reset count keeps the self-clearing reset window to a handful of cycles, so the bench can check it cycle by cycle.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_RESET = 2'd3
    } chan_state_e;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_LEN   = 3'd1;
    localparam logic [2:0] A_START = 3'd2;
    localparam logic [2:0] A_KICK  = 3'd3;
    localparam logic [2:0] A_HEAD  = 3'd4;
    localparam logic [2:0] A_STAT  = 3'd5;

endpackage

// File: rtl/tx_ring_chan_fsm.sv
module tx_ring_chan_fsm
    import tx_ring_pkg::*;
#(
    parameter int RST_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_en,
    input  logic ctl_rst,
    input  logic fatal_evt,
    input  logic pend,
    input  logic eng_busy,
    output logic run,
    output logic quiescent,
    output logic in_reset
);
    localparam int CW = $clog2(RST_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(RST_CYC - 1);

    chan_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          may_enable;

    assign may_enable = ctl_wr && ctl_en && !pend && !fatal_evt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // reset duration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q != ST_RESET) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctl_wr && ctl_rst)  state_d = ST_RESET;
                else if (may_enable)    state_d = ST_RUN;
            end
            ST_RUN: begin
                if (ctl_wr && ctl_rst)          state_d = ST_RESET;
                else if (fatal_evt)             state_d = ST_DRAIN;
                else if (ctl_wr && !ctl_en)     state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (ctl_wr && ctl_rst)  state_d = ST_RESET;
                else if (may_enable)    state_d = ST_RUN;
                else if (!eng_busy)     state_d = ST_IDLE;
            end
            ST_RESET: begin
                if (cnt_q == CNT_LAST)  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run       = 1'b0;
        quiescent = 1'b0;
        in_reset  = 1'b0;
        unique case (state_q)
            ST_IDLE:  quiescent = 1'b1;
            ST_RUN:   run       = 1'b1;
            ST_DRAIN: ;
            ST_RESET: in_reset  = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/tx_ring_head.sv
module tx_ring_head #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [IDX_W-1:0] len_eff,
    output logic [IDX_W-1:0] head,
    output logic             hwrap
);
    logic [IDX_W:0] nxt;
    logic           at_end;

    assign nxt    = {1'b0, head} + {{IDX_W{1'b0}}, 1'b1};
    assign at_end = (nxt >= {1'b0, len_eff});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            hwrap <= 1'b0;
        end else if (clr) begin
            head  <= '0;
            hwrap <= 1'b0;
        end else if (adv) begin
            if (at_end) begin
                head  <= '0;
                hwrap <= ~hwrap;
            end else begin
                head  <= nxt[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/tx_ring_tail.sv
module tx_ring_tail #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             kick_wr,
    input  logic [IDX_W-1:0] kick_tail,
    input  logic             kick_wrap,
    input  logic             run,
    input  logic [IDX_W-1:0] len_eff,
    input  logic [IDX_W-1:0] head,
    input  logic             hwrap,
    input  logic             ovf_clr,
    output logic [IDX_W-1:0] tail,
    output logic             twrap,
    output logic             ovf_flag,
    output logic             ovf_evt
);
    logic out_of_range;
    logic order_bad;

    assign out_of_range = (kick_tail >= len_eff);
    assign order_bad    = (kick_wrap == hwrap) ? (kick_tail < head)
                                               : (kick_tail > head);
    assign ovf_evt      = kick_wr && run && (out_of_range || order_bad);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail  <= '0;
            twrap <= 1'b0;
        end else if (clr) begin
            tail  <= '0;
            twrap <= 1'b0;
        end else if (kick_wr) begin
            tail  <= kick_tail;
            twrap <= kick_wrap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (clr) begin
            ovf_flag <= 1'b0;
        end else if (ovf_evt) begin
            ovf_flag <= 1'b1;
        end else if (ovf_clr) begin
            ovf_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tx_ring_ctrl.sv
module tx_ring_ctrl
    import tx_ring_pkg::*;
#(
    parameter int IDX_W   = 16,
    parameter int GRAN    = 5,
    parameter int RST_CYC = 4,
    parameter int DW      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [2:0]       rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic             cons_req,
    output logic             cons_ack,
    input  logic             eng_busy,
    input  logic             fatal_in,
    output logic             enable,
    output logic             quiescent,
    output logic             full,
    output logic             empty,
    output logic [IDX_W-1:0] head_idx,
    output logic             head_wrap
);
    logic             run, in_reset;
    logic [IDX_W-1:0] len_q, start_q, len_wval;
    logic [IDX_W-1:0] tail;
    logic             twrap;
    logic             ovf_flag, ovf_evt, fat_flag;
    logic             ctl_wr, len_wr, start_wr, kick_wr, stat_wr;
    logic             unused_wdata;

    assign ctl_wr   = wr_en && (wr_addr == A_CTRL);
    assign len_wr   = wr_en && (wr_addr == A_LEN)   && !run && !in_reset;
    assign start_wr = wr_en && (wr_addr == A_START) && !run && !in_reset;
    assign kick_wr  = wr_en && (wr_addr == A_KICK)  && !in_reset;
    assign stat_wr  = wr_en && (wr_addr == A_STAT)  && !in_reset;
    assign unused_wdata = ^wr_data;

    // length granularity: low bits forced to zero when GRAN > 0
    generate
        if (GRAN > 0) begin : g_gran
            assign len_wval = {wr_data[IDX_W-1:GRAN], {GRAN{1'b0}}};
        end else begin : g_nogran
            assign len_wval = wr_data[IDX_W-1:0];
        end
    endgenerate

    tx_ring_chan_fsm #(.RST_CYC(RST_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_en    (wr_data[0]),
        .ctl_rst   (wr_data[1]),
        .fatal_evt (fatal_in || ovf_evt),
        .pend      (ovf_flag || fat_flag),
        .eng_busy  (eng_busy),
        .run       (run),
        .quiescent (quiescent),
        .in_reset  (in_reset)
    );

    tx_ring_head #(.IDX_W(IDX_W)) u_head (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (in_reset),
        .adv     (cons_ack),
        .len_eff (len_q),
        .head    (head_idx),
        .hwrap   (head_wrap)
    );

    tx_ring_tail #(.IDX_W(IDX_W)) u_tail (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (in_reset),
        .kick_wr   (kick_wr),
        .kick_tail (wr_data[IDX_W-1:0]),
        .kick_wrap (wr_data[IDX_W]),
        .run       (run),
        .len_eff   (len_q),
        .head      (head_idx),
        .hwrap     (head_wrap),
        .ovf_clr   (stat_wr && wr_data[2]),
        .tail      (tail),
        .twrap     (twrap),
        .ovf_flag  (ovf_flag),
        .ovf_evt   (ovf_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            start_q <= '0;
        end else if (in_reset) begin
            len_q   <= '0;
            start_q <= '0;
        end else begin
            if (len_wr)   len_q   <= len_wval;
            if (start_wr) start_q <= wr_data[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fat_flag <= 1'b0;
        end else if (in_reset) begin
            fat_flag <= 1'b0;
        end else if (fatal_in) begin
            fat_flag <= 1'b1;
        end else if (stat_wr && wr_data[3]) begin
            fat_flag <= 1'b0;
        end
    end

    assign enable   = run;
    assign empty    = (head_idx == tail) && (head_wrap == twrap);
    assign full     = (head_idx == tail) && (head_wrap != twrap);
    assign cons_ack = cons_req && run && !empty;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data[2:0]       = {quiescent, in_reset, run};
            A_LEN:   rd_data[IDX_W-1:0] = len_q;
            A_START: rd_data[IDX_W-1:0] = start_q;
            A_KICK:  rd_data[IDX_W:0]   = {twrap, tail};
            A_HEAD:  rd_data[IDX_W:0]   = {head_wrap, head_idx};
            A_STAT:  rd_data[3:0]       = {fat_flag, ovf_flag, empty, full};
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tx_ring_ctrl_chk.sv
module tx_ring_ctrl_chk #(
    parameter int IDX_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cons_ack,
    input logic             enable,
    input logic             quiescent,
    input logic             full,
    input logic             empty,
    input logic [IDX_W-1:0] head_idx,
    input logic             fatal_in,
    input logic             ovf_flag
);
    AST_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        cons_ack |-> (enable && !empty)); // R3

    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cons_ack |=> ((head_idx == $past(head_idx) + IDX_W'(1)) || (head_idx == '0))); // R4

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R5

    AST_NO_OVF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(enable)); // R7

    AST_FATAL_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_in |=> !enable); // R9

    AST_QUIES_NOT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> !quiescent); // R11

endmodule

bind tx_ring_ctrl tx_ring_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cons_ack  (cons_ack),
    .enable    (enable),
    .quiescent (quiescent),
    .full      (full),
    .empty     (empty),
    .head_idx  (head_idx),
    .fatal_in  (fatal_in),
    .ovf_flag  (ovf_flag)
);

// File: tb/tx_ring_ctrl_bench.sv
module tx_ring_ctrl_bench;
    localparam int IW         = 8;
    localparam int GR         = 2;
    localparam int RC         = 3;
    localparam int DW         = 32;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_LEN   = 3'd1;
    localparam logic [2:0] A_START = 3'd2;
    localparam logic [2:0] A_KICK  = 3'd3;
    localparam logic [2:0] A_HEAD  = 3'd4;
    localparam logic [2:0] A_STAT  = 3'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [2:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          cons_req = 1'b0;
    logic          cons_ack;
    logic          eng_busy = 1'b0;
    logic          fatal_in = 1'b0;
    logic          enable, quiescent, full, empty, head_wrap;
    logic [IW-1:0] head_idx;

    int tests = 0;
    int fails = 0;

    // reference model
    int m_len = 0, m_head = 0, m_tail = 0;
    bit m_hw = 0, m_tw = 0, m_en = 0, m_ovf = 0, m_fat = 0;

    tx_ring_ctrl #(.IDX_W(IW), .GRAN(GR), .RST_CYC(RC), .DW(DW)) u_tx_ring_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cons_req(cons_req), .cons_ack(cons_ack),
        .eng_busy(eng_busy), .fatal_in(fatal_in), .enable(enable), .quiescent(quiescent),
        .full(full), .empty(empty), .head_idx(head_idx), .head_wrap(head_wrap)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit m_empty();
        return (m_head == m_tail) && (m_hw == m_tw);
    endfunction

    function automatic bit m_full();
        return (m_head == m_tail) && (m_hw != m_tw);
    endfunction

    function automatic logic [31:0] m_stat();
        return {28'd0, m_fat, m_ovf, m_empty(), m_full()};
    endfunction

    function automatic bit m_bad(int t, bit w);
        if (t >= m_len) return 1'b1;
        if (w == m_hw) return t < m_head;
        return t > m_head;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic kick(int t, bit w);
        if (m_en && m_bad(t, w)) begin
            m_ovf = 1'b1;
            m_en  = 1'b0;
        end
        m_tail = t; m_tw = w;
        wr(A_KICK, 32'((w << IW) | t));
    endtask

    task automatic consume();
        bit exp_ack;
        exp_ack = m_en && !m_empty();
        cons_req = 1'b1;
        #1;
        chk("R3 ack", {31'd0, cons_ack}, {31'd0, exp_ack});
        @(negedge clk);
        cons_req = 1'b0;
        if (exp_ack) begin
            m_head++;
            if (m_head >= m_len) begin
                m_head = 0;
                m_hw = ~m_hw;
            end
        end
    endtask

    task automatic check_ring(string tag);
        logic [31:0] v;
        rd(A_HEAD, v);
        chk({tag, " head"}, v, 32'((m_hw << IW) | m_head));
        rd(A_STAT, v);
        chk({tag, " stat"}, v, m_stat());
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_0001));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h4);
        rd(A_HEAD, v); chk("R1 head", v, 32'h0);
        rd(A_STAT, v); chk("R1 stat", v, 32'h2);

        // R2 length granularity
        wr(A_LEN, 32'h0F); m_len = 12;
        rd(A_LEN, v); chk("R2 len", v, 32'h0C);
        wr(A_START, 32'h55);
        rd(A_START, v); chk("R10 start pre", v, 32'h55);

        // R11 enable clears quiescent
        wr(A_CTRL, 32'h1); m_en = 1'b1;
        rd(A_CTRL, v); chk("R11 ctrl en", v, 32'h1);
        chk("R11 quies port", {31'd0, quiescent}, 32'h0);

        // R3 consume on empty ring
        consume();
        check_ring("R3 empty");

        // R3 fill five and drain
        kick(5, 1'b0);
        check_ring("R5 partial");
        for (int i = 0; i < 5; i++) consume();
        check_ring("R3 drained");

        // R5 full ring
        kick(5, 1'b1);
        check_ring("R5 full");

        // R4 wrap
        for (int i = 0; i < 7; i++) consume();
        rd(A_HEAD, v); chk("R4 wrap", v, 32'h100);
        for (int i = 0; i < 5; i++) consume();
        check_ring("R4 after");

        // R10 config locked while enabled
        wr(A_LEN, 32'h20);
        rd(A_LEN, v); chk("R10 len", v, 32'h0C);
        wr(A_START, 32'h11);
        rd(A_START, v); chk("R10 start", v, 32'h55);

        // random mix of legal kicks and consumes (R3 R4 R5)
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 2));
            if (op == 0) begin
                int occ, space, k, nt;
                bit nw;
                occ   = (m_tw == m_hw) ? (m_tail - m_head) : (m_len - m_head + m_tail);
                space = m_len - occ;
                k     = int'($urandom_range(0, space));
                nt    = m_tail + k;
                nw    = m_tw;
                if (nt >= m_len) begin
                    nt = nt - m_len;
                    nw = ~nw;
                end
                kick(nt, nw);
            end else begin
                consume();
            end
            check_ring("R5 rand");
        end

        // R11 drain waits for engine
        while (!m_empty()) consume();
        eng_busy = 1'b1;
        wr(A_CTRL, 32'h0); m_en = 1'b0;
        rd(A_CTRL, v); chk("R11 drain", v, 32'h0);
        @(negedge clk);
        chk("R11 busy hold", {31'd0, quiescent}, 32'h0);
        eng_busy = 1'b0;
        @(negedge clk);
        rd(A_CTRL, v); chk("R11 idle", v, 32'h4);
        wr(A_CTRL, 32'h1); m_en = 1'b1;

        // R6 wrap contradiction
        if (m_head > 0) kick(m_head - 1, m_hw);
        else            kick(1, ~m_hw);
        chk("R6 en drop", {31'd0, enable}, 32'h0);
        rd(A_STAT, v); chk("R6 ovf", v, m_stat());
        @(negedge clk);
        rd(A_CTRL, v); chk("R6 idle", v, 32'h4);

        // R9 enable refused while pending
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, v); chk("R9 ovf block", v, 32'h4);
        wr(A_STAT, 32'h4); m_ovf = 1'b0;
        rd(A_STAT, v); chk("R6 clear", v, m_stat());

        // R7 bad kick while disabled
        kick(200, m_hw);
        rd(A_STAT, v); chk("R7 no ovf", v, m_stat());
        kick(m_head, m_hw);

        // R6 tail out of range
        wr(A_CTRL, 32'h1); m_en = 1'b1;
        kick(m_len, m_hw);
        rd(A_STAT, v); chk("R6 range", v, m_stat());
        chk("R6 range en", {31'd0, enable}, 32'h0);
        wr(A_STAT, 32'h4); m_ovf = 1'b0;
        kick(m_head, m_hw);
        wr(A_CTRL, 32'h1); m_en = 1'b1;
        rd(A_CTRL, v); chk("R9 reenable", v, 32'h1);

        // R9 external fatal
        fatal_in = 1'b1;
        @(negedge clk);
        fatal_in = 1'b0; m_en = 1'b0; m_fat = 1'b1;
        chk("R9 fatal en", {31'd0, enable}, 32'h0);
        rd(A_STAT, v); chk("R9 fatal stat", v, m_stat());
        @(negedge clk);
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, v); chk("R9 fatal block", v, 32'h4);
        wr(A_STAT, 32'h8); m_fat = 1'b0;
        wr(A_CTRL, 32'h1); m_en = 1'b1;
        rd(A_CTRL, v); chk("R9 fatal clear", v, 32'h1);

        // R8 self-clearing reset
        kick((m_head + 3) % m_len, ((m_head + 3) >= m_len) ? ~m_hw : m_hw);
        wr(A_CTRL, 32'h2);
        rd(A_CTRL, v); chk("R8 busy", v, 32'h2);
        repeat (RC) @(negedge clk);
        rd(A_CTRL, v);  chk("R8 done", v, 32'h4);
        rd(A_LEN, v);   chk("R8 len", v, 32'h0);
        rd(A_START, v); chk("R8 start", v, 32'h0);
        rd(A_KICK, v);  chk("R8 tail", v, 32'h0);
        rd(A_HEAD, v);  chk("R8 head", v, 32'h0);
        rd(A_STAT, v);  chk("R8 stat", v, 32'h2);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule